// File: doc/BRIEF.md
# Programmable Down-Counting Reload Timer

A down counter of parameterised width, run by a small register port. Software does the following:
- loads a start value into a reload register;
- arms the timer with an enable bit;
- starts the timer by writing a start-strobe bit.

Each pulse on the `tick` input moves the counter down by one. It stands in for the divided timer clock.

When a tick arrives while the counter already holds zero, an underflow event occurs. The event sets a sticky flag and can raise an interrupt. What the counter does next depends on the mode:
- **Single-shot mode:** the run ends and the counter stays at zero.
- **Auto-reload mode:** the counter refills from the reload register and keeps going.

The block drives one timer waveform. Its meaning depends on the mode:
- **Single-shot mode:** it is a level that lasts for the whole run, with a selectable polarity.
- **Auto-reload mode:** it is a square wave. Its start level is selectable, and it inverts on every underflow.

A pin-select bit chooses what the pin output carries: this waveform, or a general-purpose data input passed straight through.

The register port is word wide and has one write strobe per byte. Read data is registered and appears one cycle after the address. Address 0 is the control word, address 1 the reload value, address 2 the live counter, and address 3 reads zero.

Top module: `reload_timer`

## Requirements
- R1: After reset every control bit, the reload register and the counter are 0. The irq and timer outputs are low, and the pin output follows `gpio_in`.
- R2: A write to address 0 with byte-0 strobe set, bit0 (start) = 1 and bit1 (enable) = 1 loads the counter from the reload register at that edge. Each later tick decrements it by one. Bit0 always reads 0. A start written with bit1 = 0 is ignored, and the counter keeps its value.
- R3: While the enable bit (bit1) is 0 the run is halted, ticks leave the counter unchanged, and no underflow occurs.
- R4: A tick while running with the counter at 0 is an underflow. It sets the flag (bit2). With bit4 = 0 (single-shot) the run ends and the counter stays 0. With bit4 = 1 (auto-reload) the counter reloads on that same edge and keeps running.
- R5: Writing 0 to bit2 clears the flag, and writing 1 leaves it unchanged. If a clearing write and an underflow fall on the same edge, the flag ends set.
- R6: `irq` is high exactly while both the flag (bit2) and the interrupt-enable bit (bit3) are 1.
- R7: In single-shot mode, with bit5 = 0 the timer output is high while running and low when idle. With bit5 = 1 it is low while running and high when idle.
- R8: In auto-reload mode a start sets the timer output to the value of bit5, and every underflow inverts it.
- R9: With bit6 = 0 `pin_out` follows `gpio_in`. With bit6 = 1 it carries the timer output.
- R10: Reload-register writes update only the byte lanes whose strobe is set. Bits 7 and above of the control word read as 0.
- R11: `rdata` presents the word selected by `addr` one cycle later: 0 control, 1 reload, 2 counter, 3 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| be | input | DATA_W/8 | Byte-lane write strobes |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| gpio_in | input | 1 | General-purpose level for the pin |
| irq | output | 1 | Underflow interrupt request |
| tmr_out | output | 1 | Timer waveform |
| pin_out | output | 1 | Pin level, timer or general-purpose |

## Verification
The hardest case to reach from the ports is an underflow tick that lands on the same edge as a software write clearing the flag.

To reach it, the stimulus first loads a reload value of zero and starts an auto-reload run. Once the run is going, the counter stays at zero. It then issues a control write that keeps the mode bits, omits the start bit and clears the flag, in the same cycle as a tick.

A long randomised phase then mixes small reload values, frequent ticks and random control words. This exercises start/underflow, enable/start and mode-switch collisions against the cycle-by-cycle reference model.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

  localparam int BIT_START = 0;
  localparam int BIT_EN    = 1;
  localparam int BIT_FLAG  = 2;
  localparam int BIT_IEN   = 3;
  localparam int BIT_AUTO  = 4;
  localparam int BIT_LVL   = 5;
  localparam int BIT_PIN   = 6;

  typedef enum logic [1:0] {
    ADR_CTRL   = 2'd0,
    ADR_RELOAD = 2'd1,
    ADR_COUNT  = 2'd2,
    ADR_NONE   = 2'd3
  } tmr_addr_e;

  typedef struct packed {
    logic pin_sel;
    logic lvl;
    logic auto_rl;
    logic ien;
    logic flag;
    logic en;
  } tmr_ctrl_t;

endpackage

// File: rtl/reload_timer_regs.sv
module reload_timer_regs
  import reload_timer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag_set,
  input  logic [DATA_W-1:0] cnt,
  output tmr_ctrl_t         ctrl_q,
  output tmr_ctrl_t         ctrl_nxt,
  output logic              start,
  output logic [DATA_W-1:0] reload_q,
  output logic [DATA_W-1:0] rdata
);

  localparam int NB = DATA_W / 8;

  logic ctrl_wr;
  logic rld_wr;

  assign ctrl_wr = wr_en && (addr == ADR_CTRL) && be[0];
  assign rld_wr  = wr_en && (addr == ADR_RELOAD);

  // Next control value, before the hardware flag set is merged in.
  always_comb begin
    ctrl_nxt = ctrl_q;
    start    = 1'b0;
    if (ctrl_wr) begin
      ctrl_nxt.en      = wdata[BIT_EN];
      ctrl_nxt.ien     = wdata[BIT_IEN];
      ctrl_nxt.auto_rl = wdata[BIT_AUTO];
      ctrl_nxt.lvl     = wdata[BIT_LVL];
      ctrl_nxt.pin_sel = wdata[BIT_PIN];
      if (!wdata[BIT_FLAG]) begin
        ctrl_nxt.flag = 1'b0;
      end
      start = wdata[BIT_START] & wdata[BIT_EN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q      <= ctrl_nxt;
      ctrl_q.flag <= ctrl_nxt.flag | flag_set;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        reload_q[b*8 +: 8] <= '0;
      end else if (rld_wr && be[b]) begin
        reload_q[b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      unique case (tmr_addr_e'(addr))
        ADR_CTRL:   rdata <= {{(DATA_W-7){1'b0}}, ctrl_q.pin_sel, ctrl_q.lvl,
                              ctrl_q.auto_rl, ctrl_q.ien, ctrl_q.flag,
                              ctrl_q.en, 1'b0};
        ADR_RELOAD: rdata <= reload_q;
        ADR_COUNT:  rdata <= cnt;
        default:    rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/reload_timer_core.sv
module reload_timer_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic             en,
  input  logic             auto_rl,
  input  logic             lvl,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             tgl_q,
  output logic             flag_set
);

  logic at_zero;

  assign at_zero  = (cnt_q == '0);
  assign flag_set = en && !start && run_q && tick && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      tgl_q <= 1'b0;
    end else if (!en) begin
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= reload;
      run_q <= 1'b1;
      tgl_q <= lvl;
    end else if (run_q && tick) begin
      if (at_zero) begin
        if (auto_rl) begin
          cnt_q <= reload;
          tgl_q <= ~tgl_q;
        end else begin
          run_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/reload_timer_out.sv
module reload_timer_out (
  input  logic auto_rl,
  input  logic lvl,
  input  logic pin_sel,
  input  logic flag,
  input  logic ien,
  input  logic run,
  input  logic tgl,
  input  logic gpio_in,
  output logic irq,
  output logic tmr_out,
  output logic pin_out
);

  always_comb begin
    tmr_out = auto_rl ? tgl : (run ^ lvl);
    pin_out = pin_sel ? tmr_out : gpio_in;
    irq     = flag & ien;
  end

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                wr_en,
  input  logic [1:0]          addr,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic                gpio_in,
  output logic                irq,
  output logic                tmr_out,
  output logic                pin_out
);

  tmr_ctrl_t         ctrl_q;
  tmr_ctrl_t         ctrl_nxt;
  logic              start;
  logic              flag_set;
  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] cnt_q;
  logic              run_q;
  logic              tgl_q;

  reload_timer_regs #(.DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .be(be),
    .wdata(wdata), .flag_set(flag_set), .cnt(cnt_q), .ctrl_q(ctrl_q),
    .ctrl_nxt(ctrl_nxt), .start(start), .reload_q(reload_q), .rdata(rdata)
  );

  reload_timer_core #(.CNT_W(DATA_W)) i_core (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .en(ctrl_nxt.en),
    .auto_rl(ctrl_nxt.auto_rl), .lvl(ctrl_nxt.lvl), .reload(reload_q),
    .cnt_q(cnt_q), .run_q(run_q), .tgl_q(tgl_q), .flag_set(flag_set)
  );

  reload_timer_out i_out (
    .auto_rl(ctrl_q.auto_rl), .lvl(ctrl_q.lvl), .pin_sel(ctrl_q.pin_sel),
    .flag(ctrl_q.flag), .ien(ctrl_q.ien), .run(run_q), .tgl(tgl_q),
    .gpio_in(gpio_in), .irq(irq), .tmr_out(tmr_out), .pin_out(pin_out)
  );

endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk
  import reload_timer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic                wr_en,
  input logic [1:0]          addr,
  input logic [DATA_W/8-1:0] be,
  input logic [DATA_W-1:0]   wdata,
  input logic                start,
  input tmr_ctrl_t           ctrl,
  input logic [DATA_W-1:0]   reload,
  input logic [DATA_W-1:0]   cnt,
  input logic                run,
  input logic                irq,
  input logic                tmr_out
);

  logic clr_wr;
  assign clr_wr = wr_en && (addr == ADR_CTRL) && be[0] && !wdata[BIT_FLAG];

  a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
    start |=> (run && cnt == $past(reload)));

  a_r3_halt_idle: assert property (@(posedge clk) disable iff (rst)
    !ctrl.en |-> !run);

  a_r3_halt_holds: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.en && !wr_en) |=> $stable(cnt));

  a_r4_single_ends: assert property (@(posedge clk) disable iff (rst)
    (run && tick && cnt == '0 && !ctrl.auto_rl && !wr_en) |=> (!run && ctrl.flag));

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    ctrl.flag |=> (ctrl.flag || $past(clr_wr)));

  a_r6_irq_needs_ien: assert property (@(posedge clk) disable iff (rst)
    irq |-> ctrl.ien);

  a_r8_wave_flips: assert property (@(posedge clk) disable iff (rst)
    (run && tick && cnt == '0 && ctrl.auto_rl && !wr_en) |=> (tmr_out != $past(tmr_out)));

endmodule

bind reload_timer reload_timer_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr), .be(be),
  .wdata(wdata), .start(start), .ctrl(ctrl_q), .reload(reload_q),
  .cnt(cnt_q), .run(run_q), .irq(irq), .tmr_out(tmr_out)
);

// File: tb/test_reload_timer.sv
`timescale 1ns/1ps
module test_reload_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [1:0]  be = 2'b00;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        gpio_in = 1'b0;
  logic        irq, tmr_out, pin_out;

  int n_chk = 0;
  int n_fail = 0;
  bit live = 1'b0;

  always #2 clk = ~clk;

  reload_timer i_reload_timer (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr), .be(be),
    .wdata(wdata), .rdata(rdata), .gpio_in(gpio_in), .irq(irq),
    .tmr_out(tmr_out), .pin_out(pin_out)
  );

  // reference model
  bit m_en, m_flag, m_ien, m_auto, m_lvl, m_pin, m_run, m_wave;
  int m_reload, m_cnt;
  logic [15:0] m_rdata;
  bit n_en, n_ien, n_auto, n_lvl, n_pin, go, hit, wc;

  always @(posedge clk) begin
    if (rst) begin
      {m_en, m_flag, m_ien, m_auto, m_lvl, m_pin, m_run, m_wave} = '0;
      m_reload = 0; m_cnt = 0; m_rdata = 16'h0;
    end else begin
      case (addr)
        2'd0: m_rdata = 16'(m_pin*64 + m_lvl*32 + m_auto*16 + m_ien*8 + m_flag*4 + m_en*2);
        2'd1: m_rdata = 16'(m_reload);
        2'd2: m_rdata = 16'(m_cnt);
        default: m_rdata = 16'h0;
      endcase
      wc = wr_en && addr == 2'd0 && be[0];
      n_en = m_en; n_ien = m_ien; n_auto = m_auto; n_lvl = m_lvl; n_pin = m_pin;
      go = 1'b0; hit = 1'b0;
      if (wc) begin
        n_en = wdata[1]; n_ien = wdata[3]; n_auto = wdata[4];
        n_lvl = wdata[5]; n_pin = wdata[6];
        go = wdata[0] && wdata[1];
      end
      if (!n_en) m_run = 1'b0;
      else if (go) begin m_cnt = m_reload; m_run = 1'b1; m_wave = n_lvl; end
      else if (m_run && tick) begin
        if (m_cnt == 0) begin
          hit = 1'b1;
          if (n_auto) begin m_cnt = m_reload; m_wave = !m_wave; end
          else m_run = 1'b0;
        end else m_cnt = m_cnt - 1;
      end
      if (wc && !wdata[2]) m_flag = 1'b0;
      if (hit) m_flag = 1'b1;
      m_en = n_en; m_ien = n_ien; m_auto = n_auto; m_lvl = n_lvl; m_pin = n_pin;
      if (wr_en && addr == 2'd1) begin
        if (be[0]) m_reload = (m_reload & 32'hFF00) | int'(wdata[7:0]);
        if (be[1]) m_reload = (m_reload & 32'h00FF) | (int'(wdata[15:8]) << 8);
      end
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  bit e_wave;
  always @(negedge clk) begin
    if (live) begin
      e_wave = m_auto ? m_wave : (m_run ^ m_lvl);
      check(m_auto ? "R8 timer output" : "R7 timer output", 16'(tmr_out), 16'(e_wave));
      check("R9 pin output", 16'(pin_out), 16'(m_pin ? e_wave : gpio_in));
      check("R6 irq", 16'(irq), 16'(m_flag & m_ien));
      check("R11 read data", rdata, m_rdata);
    end
  end

  task automatic step(bit w, logic [1:0] a, logic [1:0] b, logic [15:0] d, bit t);
    wr_en = w; addr = a; be = b; wdata = d; tick = t;
    @(posedge clk); #1;
    wr_en = 1'b0; tick = 1'b0; be = 2'b00;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    step(1'b0, a, 2'b00, 16'h0, 1'b0);
    @(negedge clk); v = rdata;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  logic [15:0] v;
  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    live = 1'b1;
    @(negedge clk);
    check("R1 irq reset", 16'(irq), 16'h0);
    check("R1 tmr_out reset", 16'(tmr_out), 16'h0);
    gpio_in = 1'b1; #0.5;
    check("R1 pin follows gpio", 16'(pin_out), 16'h1);
    @(posedge clk); #1;
    rd(2'd0, v); check("R1 control reset", v, 16'h0000);

    // single-shot run
    step(1'b1, 2'd1, 2'b11, 16'h0005, 1'b0);
    step(1'b1, 2'd0, 2'b01, 16'h000B, 1'b0);
    repeat (3) step(1'b0, 2'd2, 2'b00, 16'h0, 1'b1);
    rd(2'd2, v); check("R2 countdown", v, 16'h0002);
    rd(2'd0, v); check("R2 start reads zero", v & 16'h0001, 16'h0000);
    repeat (4) step(1'b0, 2'd2, 2'b00, 16'h0, 1'b1);
    @(negedge clk);
    check("R4 flag raises irq", 16'(irq), 16'h1);
    check("R7 idle level", 16'(tmr_out), 16'h0);
    @(posedge clk); #1;
    rd(2'd2, v); check("R4 single-shot stays zero", v, 16'h0000);
    step(1'b1, 2'd0, 2'b01, 16'h000E, 1'b0);   // flag bit written 1
    rd(2'd0, v); check("R5 write one keeps flag", v & 16'h0004, 16'h0004);
    step(1'b1, 2'd0, 2'b01, 16'h000A, 1'b0);   // flag bit written 0
    rd(2'd0, v); check("R5 write zero clears", v & 16'h0004, 16'h0000);

    // halted timer ignores start and ticks
    step(1'b1, 2'd0, 2'b01, 16'h0001, 1'b0);
    repeat (3) step(1'b0, 2'd2, 2'b00, 16'h0, 1'b1);
    rd(2'd2, v); check("R3 halted counter holds", v, 16'h0000);

    // byte lanes
    step(1'b1, 2'd1, 2'b01, 16'hAB34, 1'b0);
    rd(2'd1, v); check("R10 low lane only", v, 16'h0034);
    step(1'b1, 2'd1, 2'b10, 16'h12FF, 1'b0);
    rd(2'd1, v); check("R10 high lane only", v, 16'h1234);
    step(1'b1, 2'd0, 2'b11, 16'hFFFE, 1'b0);
    rd(2'd0, v); check("R10 upper control bits zero", v & 16'hFF80, 16'h0000);
    step(1'b1, 2'd0, 2'b01, 16'h0000, 1'b0);

    // auto-reload wave, start high, pin routed
    step(1'b1, 2'd1, 2'b11, 16'h0002, 1'b0);
    step(1'b1, 2'd0, 2'b01, 16'h0073, 1'b0);
    @(negedge clk); check("R8 start level high", 16'(tmr_out), 16'h1);
    @(posedge clk); #1;
    for (int i = 0; i < 12; i++) begin
      gpio_in = i[0];
      step(1'b0, 2'd2, 2'b00, 16'h0, 1'b1);
    end

    // clear and underflow on the same edge
    step(1'b1, 2'd1, 2'b11, 16'h0000, 1'b0);
    step(1'b1, 2'd0, 2'b01, 16'h0073, 1'b0);
    step(1'b1, 2'd0, 2'b01, 16'h0072, 1'b1);
    rd(2'd0, v); check("R5 set beats clear", v & 16'h0004, 16'h0004);

    // randomised phase
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] a;
      logic [15:0] d;
      a = 2'($urandom % 4);
      d = 16'($urandom);
      if (a == 2'd1) d = 16'($urandom % 6);
      if (a == 2'd0 && ($urandom % 4) != 0) d[1] = 1'b1;
      gpio_in = 1'($urandom);
      step(($urandom % 6) == 0, a, 2'($urandom), d, ($urandom % 3) != 0);
    end

    @(negedge clk);
    live = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule